// File: doc/BRIEF.md
# Calorimeter Tower Frame Packer

This block packs the digitised samples of six front-end charge channels into a single 64-bit frame on every beam-crossing clock. The channels form two towers of three. Each sample has an 8-bit code, made of a 6-bit mantissa and a 2-bit range. Each tower also supplies a 5-bit timing value. The front end works as a four-stage pipeline, so every sample carries a 2-bit capacitor tag that should step through 0, 1, 2 and 3 in turn. The packer builds one 32-bit word per tower and registers the frame toward a serialiser.

For each tower the packer checks two things. First, the three channels must report the same capacitor tag. Second, that tag must be one step ahead, modulo 4, of the tag seen on the previous valid crossing. Either fault sets the tower's error bit. After reset, or after a rotation fault, the tracker takes the next crossing's tag as its new reference and does not flag a rotation fault on that crossing.

Each tower has a saturating counter of error crossings. A small register port reads each counter and clears it.

Top module: `tower_frame_packer`

## Requirements
- R1: After reset, `frame` is all zeros, `frame_valid` is low, and both error counters read zero.
- R2: Bit layout of a tower word, from MSB to LSB:
  - channel 0 code in [31:24]
  - channel 1 code in [23:16]
  - channel 2 code in [15:8]
  - timing value in [7:3]
  - capacitor tag in [2:1]
  - error flag in [0]

  Tower 0 occupies `frame[63:32]` and tower 1 occupies `frame[31:0]`. Within the inputs, channel g (g = 3*tower + index) uses code bits [8g+7:8g] and tag bits [2g+1:2g]. Tower t uses timing bits [5t+4:5t].
- R3: Each crossing with `in_valid` high appears on `frame` one clock later, and `frame_valid` is high in that cycle. In the cycle after a crossing with `in_valid` low, `frame_valid` is low and `frame` keeps its previous value.
- R4: If the three tags of a tower do not all match, that tower's error flag is set, and the word carries channel 0's tag.
- R5: When the tracker holds a reference, the error flag is set if channel 0's tag is not the reference plus one modulo 4. A step from 3 to 0 is not an error.
- R6: On the first valid crossing after reset, and on the first valid crossing after a rotation fault, no rotation fault is flagged. That crossing's channel 0 tag becomes the reference, and rotation checking resumes on the next valid crossing. A tag mismatch alone does not clear the reference.
- R7: A crossing with `in_valid` low changes neither the rotation reference nor the error counters.
- R8: A tower's counter adds one for each valid crossing on which that tower's error flag is set. It holds at its all-ones value instead of wrapping.
- R9: `rd_data` shows, one clock after `rd_sel` is presented, the counter value of tower `rd_sel` as it stood before that clock edge.
- R10: `cnt_clr` high zeroes the counter of tower `cnt_clr_sel` at the next edge. A clear takes priority over an increment in the same cycle, and the other tower's counter is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input samples are valid this crossing |
| ch_code | input | 48 | Six 8-bit channel codes (range and mantissa) |
| ch_cap | input | 12 | Six 2-bit capacitor tags |
| tdc | input | 10 | Two 5-bit tower timing values |
| cnt_clr | input | 1 | Clear the selected error counter |
| cnt_clr_sel | input | 1 | Tower whose counter is cleared |
| rd_sel | input | 1 | Tower whose counter is read |
| frame | output | 64 | Packed two-tower frame |
| frame_valid | output | 1 | Frame holds a new crossing |
| rd_data | output | 16 | Selected error counter value |

## Verification
The assertions assume that every input is a defined 0 or 1 on each clock edge, and that the selectors only name towers that exist. They also assume that all six channels of a crossing arrive together under one `in_valid`, so the rotation check sees exactly one tag per crossing. The stimulus meets these conditions in the following ways:
- The selectors are drawn only from 0 and 1.
- Most crossings follow a legal tag rotation.
- Tag mismatches, skipped steps and idle crossings are injected at low, fixed rates, so that both the tracking path and the reload path are exercised many times.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

  // Rotation tracker state: reload takes the next tag as reference
  typedef enum logic {
    ST_RELOAD = 1'b0,
    ST_TRACK  = 1'b1
  } track_e;

  // Width of one packed tower word
  function automatic int tower_word_width(input int ch, input int code_w,
                                          input int tdc_w, input int cap_w);
    return ch * code_w + tdc_w + cap_w + 1;
  endfunction

endpackage

// File: rtl/tdp_tower_check.sv
module tdp_tower_check
  import tdp_pkg::*;
#(
  parameter int CH     = 3,
  parameter int CODE_W = 8,
  parameter int TDC_W  = 5,
  parameter int CAP_W  = 2,
  localparam int WORD_W = tower_word_width(CH, CODE_W, TDC_W, CAP_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [CH*CODE_W-1:0] codes,
  input  logic [CH*CAP_W-1:0]  capids,
  input  logic [TDC_W-1:0]     tdc,
  output logic [WORD_W-1:0]    word_q,
  output logic                 err_pulse
);

  track_e             state;
  logic [CAP_W-1:0]   exp_cap;
  logic [CAP_W-1:0]   cap0;
  logic               agree;
  logic               rot_bad;
  logic               err_now;
  logic [WORD_W-1:0]  word_d;

  assign cap0 = capids[CAP_W-1:0];

  // Agreement of all channel tags with channel 0
  always_comb begin
    agree = 1'b1;
    for (int i = 1; i < CH; i++) begin
      if (capids[i*CAP_W +: CAP_W] != cap0) agree = 1'b0;
    end
  end

  assign rot_bad   = (state == ST_TRACK) && (cap0 != CAP_W'(exp_cap + CAP_W'(1)));
  assign err_now   = !agree || rot_bad;
  assign err_pulse = in_valid && err_now;

  // Word assembly: channel 0 at the top, then timing, tag, flag
  always_comb begin
    word_d = '0;
    for (int i = 0; i < CH; i++) begin
      word_d[WORD_W-1-i*CODE_W -: CODE_W] = codes[i*CODE_W +: CODE_W];
    end
    word_d[CAP_W+TDC_W : CAP_W+1] = tdc;
    word_d[CAP_W:1]               = cap0;
    word_d[0]                     = err_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RELOAD;
      exp_cap <= '0;
      word_q  <= '0;
    end else if (in_valid) begin
      word_q <= word_d;
      if (rot_bad) begin
        state <= ST_RELOAD;
      end else begin
        state   <= ST_TRACK;
        exp_cap <= cap0;
      end
    end
  end

  // R4: a tag mismatch is flagged in the next word
  a_r4_mismatch_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !agree) |=> word_q[0]);

  // R5: a rotation break is flagged and drops the reference
  a_r5_rotation_break: assert property (@(posedge clk) disable iff (rst)
    (in_valid && state == ST_TRACK && cap0 != CAP_W'(exp_cap + CAP_W'(1)))
      |=> (word_q[0] && state == ST_RELOAD));

  // R6: a reload crossing with agreeing tags is clean and arms tracking
  a_r6_reload_clean: assert property (@(posedge clk) disable iff (rst)
    (in_valid && state == ST_RELOAD && agree)
      |=> (!word_q[0] && state == ST_TRACK && word_q[CAP_W:1] == exp_cap));

  // R7: idle crossings leave the tracker untouched
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(state) && $stable(exp_cap) && $stable(word_q)));

endmodule

// File: rtl/tdp_err_counter.sv
module tdp_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && count != CNT_MAX) begin
      count <= count + CNT_W'(1);
    end
  end

  // R10: clear wins and zeroes the counter
  a_r10_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  // R8: saturation holds at all ones
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

  // R8: a counted error adds exactly one
  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && count != CNT_MAX) |=> (count == $past(count) + CNT_W'(1)));

  // R7: no increment and no clear keeps the value
  a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(count));

endmodule

// File: rtl/tower_frame_packer.sv
module tower_frame_packer
  import tdp_pkg::*;
#(
  parameter int NT     = 2,
  parameter int CH     = 3,
  parameter int CODE_W = 8,
  parameter int TDC_W  = 5,
  parameter int CAP_W  = 2,
  parameter int CNT_W  = 16,
  localparam int SEL_W   = (NT > 1) ? $clog2(NT) : 1,
  localparam int WORD_W  = tower_word_width(CH, CODE_W, TDC_W, CAP_W),
  localparam int FRAME_W = NT * WORD_W,
  localparam int TCODE_W = CH * CODE_W,
  localparam int TCAP_W  = CH * CAP_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [NT*TCODE_W-1:0] ch_code,
  input  logic [NT*TCAP_W-1:0]  ch_cap,
  input  logic [NT*TDC_W-1:0]   tdc,
  input  logic                  cnt_clr,
  input  logic [SEL_W-1:0]      cnt_clr_sel,
  input  logic [SEL_W-1:0]      rd_sel,
  output logic [FRAME_W-1:0]    frame,
  output logic                  frame_valid,
  output logic [CNT_W-1:0]      rd_data
);

  logic [NT-1:0]    err_pulse;
  logic [CNT_W-1:0] cnt_arr [NT];

  for (genvar t = 0; t < NT; t++) begin : g_tower
    tdp_tower_check #(
      .CH     (CH),
      .CODE_W (CODE_W),
      .TDC_W  (TDC_W),
      .CAP_W  (CAP_W)
    ) u_chk (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .codes     (ch_code[t*TCODE_W +: TCODE_W]),
      .capids    (ch_cap[t*TCAP_W +: TCAP_W]),
      .tdc       (tdc[t*TDC_W +: TDC_W]),
      .word_q    (frame[FRAME_W-1-t*WORD_W -: WORD_W]),
      .err_pulse (err_pulse[t])
    );

    tdp_err_counter #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (err_pulse[t]),
      .clr   (cnt_clr && (cnt_clr_sel == SEL_W'(t))),
      .count (cnt_arr[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_valid <= 1'b0;
      rd_data     <= '0;
    end else begin
      frame_valid <= in_valid;
      if (int'(rd_sel) < NT) rd_data <= cnt_arr[rd_sel];
      else                   rd_data <= '0;
    end
  end

  // R3: strobe follows the input valid with one cycle of latency
  a_r3_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> frame_valid);

  a_r3_valid_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!frame_valid && $stable(frame)));

endmodule

// File: tb/tower_frame_packer_bench.sv
module tower_frame_packer_bench;

  localparam int CNTW = 4;
  localparam logic [CNTW-1:0] CMAX = '1;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [47:0] ch_code;
  logic [11:0] ch_cap;
  logic [9:0]  tdc;
  logic        cnt_clr;
  logic        cnt_clr_sel;
  logic        rd_sel;
  logic [63:0] frame;
  logic        frame_valid;
  logic [CNTW-1:0] rd_data;

  always #4 clk = ~clk;

  tower_frame_packer #(.CNT_W(CNTW)) u_tower_frame_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ch_code(ch_code),
    .ch_cap(ch_cap), .tdc(tdc), .cnt_clr(cnt_clr), .cnt_clr_sel(cnt_clr_sel),
    .rd_sel(rd_sel), .frame(frame), .frame_valid(frame_valid), .rd_data(rd_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference model state
  logic [63:0]     mframe;
  bit              marm [2];
  logic [1:0]      mprev [2];
  logic [CNTW-1:0] mcnt [2];
  logic [1:0]      rot [2];

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic [23:0] c, input logic [4:0] t,
                                       input logic [1:0] cap, input bit err);
    return {c[7:0], c[15:8], c[23:16], t, cap, err};
  endfunction

  task automatic cycle(input bit v, input logic [47:0] codes, input logic [11:0] caps,
                       input logic [9:0] tdcs, input bit clr, input bit csel,
                       input bit rsel, input string tag);
    logic [CNTW-1:0] rexp;
    in_valid = v; ch_code = codes; ch_cap = caps; tdc = tdcs;
    cnt_clr = clr; cnt_clr_sel = csel; rd_sel = rsel;
    rexp = mcnt[rsel];
    for (int t = 0; t < 2; t++) begin
      logic [1:0] c0;
      bit agree, rb, err;
      c0    = caps[t*6 +: 2];
      agree = (caps[t*6+2 +: 2] == c0) && (caps[t*6+4 +: 2] == c0);
      rb    = marm[t] && (c0 != 2'(mprev[t] + 2'd1));
      err   = !agree || rb;
      if (v) begin
        mframe[63-32*t -: 32] = pack(codes[t*24 +: 24], tdcs[t*5 +: 5], c0, err);
        if (rb) marm[t] = 1'b0;
        else begin marm[t] = 1'b1; mprev[t] = c0; end
        if (err && mcnt[t] != CMAX) mcnt[t] = mcnt[t] + 1'b1;
      end
    end
    if (clr) mcnt[csel] = '0;
    @(posedge clk);
    @(negedge clk);
    check(frame_valid == v, {tag, " R3 frame_valid"}, 64'(frame_valid), 64'(v));
    check(frame == mframe, {tag, " R2 frame"}, frame, mframe);
    check(rd_data == rexp, {tag, " R9 rd_data"}, 64'(rd_data), 64'(rexp));
  endtask

  function automatic logic [11:0] caps_all(input logic [1:0] a, input logic [1:0] b);
    return {b, b, b, a, a, a};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    mframe = '0;
    for (int t = 0; t < 2; t++) begin marm[t] = 0; mprev[t] = 0; mcnt[t] = 0; end
    rst = 1'b1; in_valid = 0; ch_code = 0; ch_cap = 0; tdc = 0;
    cnt_clr = 0; cnt_clr_sel = 0; rd_sel = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(frame == 64'd0, "R1 frame after reset", frame, 64'd0);
    check(!frame_valid, "R1 frame_valid after reset", 64'(frame_valid), 64'd0);
    cycle(0, '0, '0, '0, 0, 0, 0, "R1 rd0");
    cycle(0, '0, '0, '0, 0, 0, 1, "R1 rd1");

    // R2/R6: first crossing after reset loads the tag without error
    cycle(1, 48'h66_55_44_33_22_11, caps_all(2'd2, 2'd2), {5'h0A, 5'h15}, 0, 0, 0, "R6 first");
    check(frame == 64'h112233AC_44556654, "R2 explicit layout", frame, 64'h112233AC_44556654);

    // R5: legal rotation including wrap 3 -> 0
    cycle(1, 48'h0102030405060, caps_all(2'd3, 2'd3), 10'h3F1, 0, 0, 0, "R5 step3");
    cycle(1, 48'hA0A1A2A3A4A5, caps_all(2'd0, 2'd0), 10'h155, 0, 0, 0, "R5 wrap");
    check(frame[32] == 1'b0 && frame[0] == 1'b0, "R5 wrap no error", 64'(frame[32]), 64'd0);
    cycle(1, 48'hB0B1B2B3B4B5, caps_all(2'd1, 2'd1), 10'h2AA, 0, 0, 0, "R5 step1");

    // R7: idle crossing with garbage tags changes nothing
    cycle(0, 48'hFFFFFFFFFFFF, 12'h9C3, 10'h3FF, 0, 0, 0, "R7 idle");
    cycle(1, 48'hC0C1C2C3C4C5, caps_all(2'd2, 2'd2), 10'h011, 0, 0, 0, "R7 after idle");
    check(frame[32] == 1'b0, "R7 tracking kept", 64'(frame[32]), 64'd0);

    // R4: mismatch on tower 0 (3,1,3): flagged, carries channel 0 tag
    cycle(1, 48'hD0D1D2D3D4D5, {6'b11_11_11, 2'd3, 2'd1, 2'd3}, 10'h022, 0, 0, 0, "R4 mismatch");
    check(frame[32] == 1'b1 && frame[34:33] == 2'd3, "R4 flag and tag",
          64'(frame[34:32]), 64'b111);
    cycle(1, 48'hE0E1E2E3E4E5, caps_all(2'd0, 2'd0), 10'h033, 0, 0, 0, "R6 mismatch keeps ref");
    check(frame[32] == 1'b0, "R6 reference kept after mismatch", 64'(frame[32]), 64'd0);

    // R5/R6: rotation break then reload
    cycle(1, 48'h111111111111, caps_all(2'd3, 2'd3), 10'h044, 0, 0, 0, "R5 break");
    check(frame[32] && frame[0], "R5 break flagged", 64'({frame[32], frame[0]}), 64'b11);
    cycle(1, 48'h222222222222, caps_all(2'd1, 2'd1), 10'h055, 0, 0, 0, "R6 reload");
    check(!frame[32] && !frame[0], "R6 reload clean", 64'({frame[32], frame[0]}), 64'b00);
    cycle(1, 48'h333333333333, caps_all(2'd2, 2'd2), 10'h066, 0, 0, 1, "R6 resume");

    // R8: saturation of tower 0 with repeated mismatches
    for (int i = 0; i < 20; i++)
      cycle(1, 48'(i), {6'b000000, 2'd1, 2'd1, 2'd0}, 10'(i), 0, 0, 0, "R8 sat");
    cycle(0, '0, '0, '0, 0, 0, 0, "R8 read");
    check(rd_data == CMAX, "R8 saturated value", 64'(rd_data), 64'(CMAX));

    // R10: clear beats increment; other tower unaffected
    cycle(1, '0, {2'd0, 2'd1, 2'd2, 2'd1, 2'd1, 2'd0}, '0, 1, 0, 1, "R10 clear");
    cycle(0, '0, '0, '0, 0, 0, 0, "R10 read0");
    check(rd_data == '0, "R10 cleared", 64'(rd_data), 64'd0);
    cycle(0, '0, '0, '0, 0, 0, 1, "R10 read1");

    // Random phase
    rot[0] = 2'(mprev[0] + 2'd1); rot[1] = 2'(mprev[1] + 2'd1);
    for (int n = 0; n < 4000; n++) begin
      bit v;
      logic [11:0] caps;
      v = ($urandom % 4) != 0;
      for (int t = 0; t < 2; t++) begin
        logic [1:0] c;
        c = rot[t];
        if ($urandom % 20 == 0) c = 2'($urandom);
        caps[t*6 +: 6] = {c, c, c};
        if ($urandom % 16 == 0) caps[t*6 + 2*($urandom % 3) +: 2] = 2'($urandom);
        if (v) rot[t] = 2'(caps[t*6 +: 2] + 2'd1);
      end
      cycle(v, {$urandom, $urandom} & 48'hFFFFFFFFFFFF, caps, 10'($urandom),
            ($urandom % 50) == 0, 1'($urandom), 1'($urandom), "R4 R5 R8 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule